// File: doc/BRIEF.md
# Three-Step Sequential Combination Lock

This block is a synchronous Moore controller for a lock. The lock opens only after three code values are presented in the right order. Each value arrives on a data port. A one-cycle strobe, sampled on the same clock edge as the data, marks the cycle in which a value is valid. Cycles without the strobe are idle: the data port is ignored in those cycles.

The controller drives a two-bit selector. The selector steers a multiplexer over the three stored codes. An equality comparator checks the selected code against the presented value and produces the hit condition that the sequencer acts on. If a value mismatches at any step, the lock falls into a fault state. Reaching the open state after the third code, or falling into the fault state, is final until a synchronous reset.

Top module: `combo_lock`

## Requirements
- R1: While `rst` is high at a rising clock edge, the controller returns to the first checking step. After that edge, `code_sel` is 0 and `is_open` is 0.
- R2: `code_sel` encodes the controller's position. It is 0, 1 and 2 in the first, second and third checking steps. It is 3 in both the open state and the fault state.
- R3: In the first or second checking step, a strobed value equal to the selected code moves the controller to the next step at the next edge. `code_sel` rises by one and `is_open` stays 0.
- R4: In the third checking step, a strobed value equal to the third code moves the controller to the open state at the next edge. After that edge, `is_open` is 1.
- R5: In any checking step, a strobed value that differs from the selected code moves the controller to the fault state at the next edge. After that edge, `code_sel` is 3 and `is_open` is 0.
- R6: In a cycle where `entry_new` is 0, the state is held, whatever value is on `entry_val`.
- R7: `is_open` is 1 only in the open state. It is 0 in every checking step and in the fault state.
- R8: The open state ignores all further strobed values and is left only by reset.
- R9: The fault state ignores all further strobed values, including correct codes, and is left only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| entry_val | input | W | Value being presented |
| entry_new | input | 1 | Strobe: entry_val is valid this cycle |
| code_sel | output | 2 | Stored-code selector / position indication |
| is_open | output | 1 | 1 when the lock is open |

## Verification
The bench builds the lock with a 3-bit entry width and the codes 5, 2 and 6. This makes the value space small enough to sweep every value at every one of the three positions. Each sweep starts from reset, so both the single matching value and all seven mismatching values are tried at each step, and the fault state is reached from every checking step. Each correct prefix has idle cycles between its strobed values, and those idle cycles carry changing data. After each sequence, the open and fault states are probed with further strobed values.

// File: rtl/lock_pkg.sv
package lock_pkg;

  typedef enum logic [2:0] {
    ST_CHK0  = 3'd0,
    ST_CHK1  = 3'd1,
    ST_CHK2  = 3'd2,
    ST_OPEN  = 3'd3,
    ST_FAULT = 3'd4
  } lock_state_e;

  localparam int unsigned SEL_W = 2;
  localparam logic [SEL_W-1:0] SEL_DONE = 2'd3;

  // Selector value shown for each state.
  function automatic logic [SEL_W-1:0] sel_of(input lock_state_e s);
    case (s)
      ST_CHK0: sel_of = 2'd0;
      ST_CHK1: sel_of = 2'd1;
      ST_CHK2: sel_of = 2'd2;
      default: sel_of = SEL_DONE;
    endcase
  endfunction

  // Transition function: strobe gates every move; OPEN and FAULT absorb.
  function automatic lock_state_e next_of(input lock_state_e s,
                                          input logic strobe,
                                          input logic hit);
    next_of = s;
    if (strobe) begin
      case (s)
        ST_CHK0: next_of = hit ? ST_CHK1 : ST_FAULT;
        ST_CHK1: next_of = hit ? ST_CHK2 : ST_FAULT;
        ST_CHK2: next_of = hit ? ST_OPEN : ST_FAULT;
        default: next_of = s;
      endcase
    end
  endfunction

endpackage

// File: rtl/lock_code_mux.sv
module lock_code_mux #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] CODE_A = 'h3,
  parameter logic [W-1:0] CODE_B = 'hA,
  parameter logic [W-1:0] CODE_C = 'h7
) (
  input  logic [1:0]   sel,
  output logic [W-1:0] code
);
  localparam int unsigned SLOTS = 4;
  logic [W-1:0] slot [SLOTS];

  generate
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      if (i == 0)      begin : g_a assign slot[i] = CODE_A; end
      else if (i == 1) begin : g_b assign slot[i] = CODE_B; end
      else if (i == 2) begin : g_c assign slot[i] = CODE_C; end
      else             begin : g_z assign slot[i] = '0;     end
    end
  endgenerate

  assign code = slot[sel];
endmodule

// File: rtl/lock_cmp.sv
module lock_cmp #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         hit
);
  assign hit = (a == b);
endmodule

// File: rtl/lock_seq.sv
module lock_seq
  import lock_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic             hit,
  output logic [SEL_W-1:0] sel,
  output logic             opened
);
  lock_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_CHK0;
    else     state_q <= next_of(state_q, strobe, hit);
  end

  assign sel    = sel_of(state_q);
  assign opened = (state_q == ST_OPEN);
endmodule

// File: rtl/combo_lock.sv
module combo_lock #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] CODE_A = 'h3,
  parameter logic [W-1:0] CODE_B = 'hA,
  parameter logic [W-1:0] CODE_C = 'h7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] entry_val,
  input  logic         entry_new,
  output logic [1:0]   code_sel,
  output logic         is_open
);
  logic [W-1:0] ref_code;
  logic         match_w;

  lock_code_mux #(.W(W), .CODE_A(CODE_A), .CODE_B(CODE_B), .CODE_C(CODE_C)) u_mux (
    .sel(code_sel), .code(ref_code)
  );

  lock_cmp #(.W(W)) u_cmp (
    .a(entry_val), .b(ref_code), .hit(match_w)
  );

  lock_seq u_seq (
    .clk(clk), .rst(rst), .strobe(entry_new), .hit(match_w),
    .sel(code_sel), .opened(is_open)
  );
endmodule

// File: rtl/lock_chk.sv
module lock_chk (
  input logic       clk,
  input logic       rst,
  input logic       entry_new,
  input logic       hit,
  input logic [1:0] code_sel,
  input logic       is_open
);
  // R1
  reset_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (code_sel == 2'd0 && !is_open));
  // R3
  step_a_chk: assert property (@(posedge clk) disable iff (rst)
    (code_sel == 2'd0 && entry_new && hit) |=> (code_sel == 2'd1 && !is_open));
  // R3
  step_b_chk: assert property (@(posedge clk) disable iff (rst)
    (code_sel == 2'd1 && entry_new && hit) |=> (code_sel == 2'd2 && !is_open));
  // R4
  unlock_chk: assert property (@(posedge clk) disable iff (rst)
    (code_sel == 2'd2 && entry_new && hit) |=> is_open);
  // R5
  fault_chk: assert property (@(posedge clk) disable iff (rst)
    (code_sel != 2'd3 && entry_new && !hit) |=> (code_sel == 2'd3 && !is_open));
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !entry_new |=> ($stable(code_sel) && $stable(is_open)));
  // R2
  open_sel_chk: assert property (@(posedge clk) disable iff (rst)
    is_open |-> code_sel == 2'd3);
  // R8
  open_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    is_open |=> is_open);
  // R9
  fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (code_sel == 2'd3 && !is_open) |=> (code_sel == 2'd3 && !is_open));
  // R7
  open_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(is_open) |-> ($past(code_sel) == 2'd2 && $past(entry_new)));
endmodule

bind combo_lock lock_chk u_chk (
  .clk(clk), .rst(rst), .entry_new(entry_new), .hit(match_w),
  .code_sel(code_sel), .is_open(is_open)
);

// File: tb/sim_combo_lock.sv
`timescale 1ns/1ps
module sim_combo_lock;
  localparam int unsigned W = 3;
  localparam logic [W-1:0] KA = 3'd5;
  localparam logic [W-1:0] KB = 3'd2;
  localparam logic [W-1:0] KC = 3'd6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] entry_val = '0;
  logic entry_new = 1'b0;
  logic [1:0] code_sel;
  logic is_open;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  combo_lock #(.W(W), .CODE_A(KA), .CODE_B(KB), .CODE_C(KC)) u0 (
    .clk(clk), .rst(rst), .entry_val(entry_val), .entry_new(entry_new),
    .code_sel(code_sel), .is_open(is_open)
  );

  function automatic logic [W-1:0] key_at(input int p);
    return (p == 0) ? KA : (p == 1) ? KB : KC;
  endfunction

  task automatic expect_out(input string req, input logic [1:0] es, input logic eo);
    checks++;
    if (code_sel !== es || is_open !== eo) begin
      failures++;
      $display("FAIL %s: code_sel=%0d is_open=%0b expected code_sel=%0d is_open=%0b",
               req, code_sel, is_open, es, eo);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; entry_new = 1'b0;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic present(input logic [W-1:0] v, input logic s);
    @(negedge clk); entry_val = v; entry_new = s;
    @(posedge clk); #1;
    entry_new = 1'b0;
  endtask

  initial begin
    do_reset();
    expect_out("R1", 2'd0, 1'b0);

    for (int p = 0; p < 3; p++) begin
      for (int v = 0; v < (1 << W); v++) begin
        do_reset();
        expect_out("R1", 2'd0, 1'b0);
        for (int k = 0; k < p; k++) begin
          present(W'(v + k + 1), 1'b0);           // idle cycle, value ignored
          expect_out("R6", 2'(k), 1'b0);
          present(key_at(k), 1'b1);
          expect_out("R3", 2'(k + 1), 1'b0);
        end
        present(W'(v), 1'b1);
        if (W'(v) == key_at(p)) begin
          if (p < 2) expect_out("R3", 2'(p + 1), 1'b0);
          else begin
            expect_out("R4", 2'd3, 1'b1);
            expect_out("R2", 2'd3, 1'b1);
            present(W'(v + 1), 1'b1);
            expect_out("R8", 2'd3, 1'b1);
            present(KA, 1'b1);
            expect_out("R8", 2'd3, 1'b1);
          end
        end else begin
          expect_out("R5", 2'd3, 1'b0);
          present(key_at(p), 1'b1);
          expect_out("R9", 2'd3, 1'b0);
          present(KA, 1'b1);
          expect_out("R9", 2'd3, 1'b0);
          expect_out("R7", 2'd3, 1'b0);
        end
      end
    end

    // Reset leaves the open state
    do_reset();
    present(KA, 1'b1); present(KB, 1'b1); present(KC, 1'b1);
    expect_out("R4", 2'd3, 1'b1);
    do_reset();
    expect_out("R1", 2'd0, 1'b0);
    present(KB, 1'b0);
    expect_out("R6", 2'd0, 1'b0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule